// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block gives two processors, one on a left port and one on a right port, a set of eight hardware token flags for claiming and releasing shared resources. Each port has its own select, output enable, read/write strobe, address and data lines. A processor claims a token by writing a zero to a flag and then reading it back. A read of zero means the claim succeeded. A read of one means the other side holds the token. Writing a one gives the token back.

Every flag keeps one request latch per side. Contention is settled inside each flag cell. A request made while the other side owns the flag waits in its latch. When the owner releases, ownership passes straight to the waiting side. A read captures the flag value when the access starts and holds it until select or output enable drops. A processor that polls a flag must therefore end each access and start a new one to see a change. Both ports run on one clock and share one synchronous reset.

Top module: `sem_bank`

## Requirements
- R1: The low three address bits choose one of eight flags. All higher address bits are ignored for both writes and reads.
- R2: On a write, only data bit 0 matters. Writing 0 puts a request in the writing side's latch for the addressed flag. Writing 1 clears that side's request. All other data bits are ignored.
- R3: A side that writes 0 to a free flag becomes its owner. From the next cycle the owner reads 0 and the other side reads 1. The two sides never both read 0 from the same flag.
- R4: Only the owning side can release a flag. When the non-owner writes 1, ownership does not change.
- R5: When a side writes 0 to a flag the other side owns, its request is held as pending and that side keeps reading 1. When the owner then writes 1, the pending side becomes owner and reads 0.
- R6: When the owner writes 1 and no request is pending, the flag becomes free and both sides read 1.
- R7: A read drives the flag value onto every data bit, so the bus returns either all ones or all zeros.
- R8: The read value is captured in the first cycle in which both select and output enable are high. It stays frozen while both stay high, even if the flag changes state.
- R9: When both sides write 0 to the same free flag in the same clock cycle, the left side becomes owner and the right request stays pending.
- R10: A synchronous active-high reset sets every request latch on both sides to "no request" and frees all eight flags, so every flag reads 1 on both sides.
- R11: A write takes place on the rising clock edge when select is high and read/write is low. The read data are driven, and the drive-enable output is high, only while select, output enable and read/write are all high. At all other times the data output is zero.
- R12: If a pending side withdraws its request by writing 1 before the owner releases, the flag becomes free when the owner releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left semaphore select, active high |
| l_oe | input | 1 | Left output enable, active high |
| l_rd_wr | input | 1 | Left direction: 1 = read, 0 = write |
| l_addr | input | ADDR_W | Left address; only bits [2:0] are used |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left read data: the flag value on every bit |
| l_rd_en | output | 1 | High while the left read data are driven |
| r_sel | input | 1 | Right semaphore select, active high |
| r_oe | input | 1 | Right output enable, active high |
| r_rd_wr | input | 1 | Right direction: 1 = read, 0 = write |
| r_addr | input | ADDR_W | Right address; only bits [2:0] are used |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right read data: the flag value on every bit |
| r_rd_en | output | 1 | High while the right read data are driven |

## Verification
The bench targets these corner cases:

- **Same-cycle claim.** Both ports write zero to one free flag in the same cycle. A design without a fixed winner would give the token to both sides or to neither.
- **Handover.** The right side requests a flag the left side owns, then the left side releases. A design that drops pending requests would leave the flag free instead of handing it to the waiting side.
- **Withdrawn request.** The right side cancels its pending request before the left side releases. The flag must end up free, and a design that forgot the cancellation would wrongly hand it over.
- **Frozen read.** A long read runs while the other port releases the flag. A design that does not hold its read value would show the new owner's zero in the middle of the access.
- **Ignored bits and reset.** Writes use high address bits and stray data bits. A design that decoded too many bits would hit the wrong flag or mistake the request. A reset in the middle of the run must free flags that are still held.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

    localparam int unsigned FLAG_CNT   = 8;
    localparam int unsigned FLAG_IDX_W = $clog2(FLAG_CNT);

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // One decoded port command. Request latches are active low: 0 = request.
    typedef struct packed {
        logic                  wr;
        logic [FLAG_IDX_W-1:0] idx;
        logic                  bit_val;
    } sem_cmd_t;

    // Ownership after this cycle's latch values are known.
    // On a same-cycle claim of a free flag the left side wins.
    function automatic owner_e next_owner(owner_e cur, logic lat_l, logic lat_r);
        owner_e nxt;
        case (cur)
            OWN_NONE:  nxt = !lat_l ? OWN_LEFT  : (!lat_r ? OWN_RIGHT : OWN_NONE);
            OWN_LEFT:  nxt =  lat_l ? (!lat_r ? OWN_RIGHT : OWN_NONE) : OWN_LEFT;
            OWN_RIGHT: nxt =  lat_r ? (!lat_l ? OWN_LEFT  : OWN_NONE) : OWN_RIGHT;
            default:   nxt = OWN_NONE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 18
) (
    input  logic              sel,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output sem_cmd_t          cmd
);

    // Upper address bits and upper data bits take no part in semaphore access.
    logic unused_hi;
    assign unused_hi = ^{addr[ADDR_W-1:FLAG_IDX_W], wdata[DATA_W-1:1]};

    always_comb begin
        cmd.wr      = sel && !rd_wr;
        cmd.idx     = addr[FLAG_IDX_W-1:0];
        cmd.bit_val = wdata[0];
    end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_bank_pkg::*;
#(
    parameter int unsigned IDX = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  sem_cmd_t cmd_l,
    input  sem_cmd_t cmd_r,
    output logic     view_l,
    output logic     view_r,
    output logic     lat_l,
    output logic     lat_r
);

    localparam logic [FLAG_IDX_W-1:0] MY_IDX = IDX[FLAG_IDX_W-1:0];

    logic   lat_l_q, lat_r_q, lat_l_d, lat_r_d;
    owner_e own_q, own_d;

    always_comb begin
        lat_l_d = (cmd_l.wr && cmd_l.idx == MY_IDX) ? cmd_l.bit_val : lat_l_q;
        lat_r_d = (cmd_r.wr && cmd_r.idx == MY_IDX) ? cmd_r.bit_val : lat_r_q;
        own_d   = next_owner(own_q, lat_l_d, lat_r_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_l_q <= 1'b1;
            lat_r_q <= 1'b1;
            own_q   <= OWN_NONE;
        end else begin
            lat_l_q <= lat_l_d;
            lat_r_q <= lat_r_d;
            own_q   <= own_d;
        end
    end

    // Active-low flag views: a side reads 0 only while it owns the token.
    assign view_l = (own_q != OWN_LEFT);
    assign view_r = (own_q != OWN_RIGHT);
    assign lat_l  = lat_l_q;
    assign lat_r  = lat_r_q;

endmodule

// File: rtl/sem_read_capture.sv
module sem_read_capture #(
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              oe,
    input  logic              rd_wr,
    input  logic              live,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_en
);

    logic active, active_q, first, held_q, cur_bit;

    assign active  = sel && oe;
    assign first   = active && !active_q;
    assign cur_bit = first ? live : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            held_q   <= 1'b1;
        end else begin
            active_q <= active;
            if (first) begin
                held_q <= live;
            end
        end
    end

    assign rd_en = active && rd_wr;
    assign rdata = rd_en ? {DATA_W{cur_bit}} : '0;

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_oe,
    input  logic              l_rd_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rd_en,
    input  logic              r_sel,
    input  logic              r_oe,
    input  logic              r_rd_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rd_en
);

    sem_cmd_t            l_cmd, r_cmd;
    logic [FLAG_CNT-1:0] view_l, view_r, lat_l, lat_r;

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sel(l_sel), .rd_wr(l_rd_wr), .addr(l_addr), .wdata(l_wdata), .cmd(l_cmd)
    );

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sel(r_sel), .rd_wr(r_rd_wr), .addr(r_addr), .wdata(r_wdata), .cmd(r_cmd)
    );

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
        sem_flag_cell #(.IDX(g)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .cmd_l  (l_cmd),
            .cmd_r  (r_cmd),
            .view_l (view_l[g]),
            .view_r (view_r[g]),
            .lat_l  (lat_l[g]),
            .lat_r  (lat_r[g])
        );
    end

    sem_read_capture #(.DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst(rst), .sel(l_sel), .oe(l_oe), .rd_wr(l_rd_wr),
        .live(view_l[l_cmd.idx]), .rdata(l_rdata), .rd_en(l_rd_en)
    );

    sem_read_capture #(.DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst(rst), .sel(r_sel), .oe(r_oe), .rd_wr(r_rd_wr),
        .live(view_r[r_cmd.idx]), .rdata(r_rdata), .rd_en(r_rd_en)
    );

endmodule

// File: rtl/sem_bank_checker.sv
module sem_bank_checker
    import sem_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 18
) (
    input logic                clk,
    input logic                rst,
    input logic                l_sel,
    input logic                l_oe,
    input logic                l_rd_wr,
    input logic [ADDR_W-1:0]   l_addr,
    input logic [DATA_W-1:0]   l_wdata,
    input logic [DATA_W-1:0]   l_rdata,
    input logic                l_rd_en,
    input logic                r_sel,
    input logic                r_oe,
    input logic                r_rd_wr,
    input logic [ADDR_W-1:0]   r_addr,
    input logic [DATA_W-1:0]   r_wdata,
    input logic [DATA_W-1:0]   r_rdata,
    input logic                r_rd_en,
    input logic [FLAG_CNT-1:0] view_l,
    input logic [FLAG_CNT-1:0] view_r,
    input logic [FLAG_CNT-1:0] lat_r
);

    logic unused_chk;
    assign unused_chk = ^{l_addr[ADDR_W-1:FLAG_IDX_W], r_addr[ADDR_W-1:FLAG_IDX_W],
                          l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    logic [FLAG_CNT-1:0] l_rel, l_clm, r_rel, r_clm;
    always_comb begin
        for (int i = 0; i < FLAG_CNT; i++) begin
            l_rel[i] = l_sel && !l_rd_wr && (l_addr[FLAG_IDX_W-1:0] == i[FLAG_IDX_W-1:0]) &&  l_wdata[0];
            l_clm[i] = l_sel && !l_rd_wr && (l_addr[FLAG_IDX_W-1:0] == i[FLAG_IDX_W-1:0]) && !l_wdata[0];
            r_rel[i] = r_sel && !r_rd_wr && (r_addr[FLAG_IDX_W-1:0] == i[FLAG_IDX_W-1:0]) &&  r_wdata[0];
            r_clm[i] = r_sel && !r_rd_wr && (r_addr[FLAG_IDX_W-1:0] == i[FLAG_IDX_W-1:0]) && !r_wdata[0];
        end
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst) (view_l | view_r) == {FLAG_CNT{1'b1}}); // R3

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_chk
        AST_LEFT_KEEPS: assert property (@(posedge clk) disable iff (rst) (!view_l[g] && !l_rel[g]) |=> !view_l[g]); // R4
        AST_RIGHT_KEEPS: assert property (@(posedge clk) disable iff (rst) (!view_r[g] && !r_rel[g]) |=> !view_r[g]); // R4
        AST_HANDOVER_R: assert property (@(posedge clk) disable iff (rst) (!view_l[g] && l_rel[g] && !lat_r[g] && !r_rel[g]) |=> !view_r[g]); // R5
        AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst) (view_l[g] && view_r[g] && l_clm[g] && r_clm[g]) |=> !view_l[g]); // R9
    end

    AST_L_UNIFORM: assert property (@(posedge clk) disable iff (rst) l_rd_en |-> (l_rdata == '0 || l_rdata == '1)); // R7
    AST_R_UNIFORM: assert property (@(posedge clk) disable iff (rst) r_rd_en |-> (r_rdata == '0 || r_rdata == '1)); // R7
    AST_L_FROZEN: assert property (@(posedge clk) disable iff (rst) (l_sel && l_oe && l_rd_wr && $past(l_sel && l_oe && l_rd_wr)) |-> $stable(l_rdata)); // R8
    AST_R_FROZEN: assert property (@(posedge clk) disable iff (rst) (r_sel && r_oe && r_rd_wr && $past(r_sel && r_oe && r_rd_wr)) |-> $stable(r_rdata)); // R8
    AST_L_QUIET: assert property (@(posedge clk) disable iff (rst) !(l_sel && l_oe && l_rd_wr) |-> (l_rdata == '0 && !l_rd_en)); // R11
    AST_R_QUIET: assert property (@(posedge clk) disable iff (rst) !(r_sel && r_oe && r_rd_wr) |-> (r_rdata == '0 && !r_rd_en)); // R11

endmodule

bind sem_bank sem_bank_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_oe(l_oe), .l_rd_wr(l_rd_wr), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rd_en(l_rd_en),
    .r_sel(r_sel), .r_oe(r_oe), .r_rd_wr(r_rd_wr), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rd_en(r_rd_en),
    .view_l(view_l), .view_r(view_r), .lat_r(lat_r)
);

// File: tb/sem_bank_test.sv
module sem_bank_test;

    localparam int AW = 13;
    localparam int DW = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_sel = 0, l_oe = 0, l_rd_wr = 1, r_sel = 0, r_oe = 0, r_rd_wr = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_rd_en, r_rd_en;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] l_exp_q[$], r_exp_q[$];
    string         l_tag_q[$], r_tag_q[$];

    always #5 clk = ~clk;

    sem_bank #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_oe(l_oe), .l_rd_wr(l_rd_wr), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rd_en(l_rd_en),
        .r_sel(r_sel), .r_oe(r_oe), .r_rd_wr(r_rd_wr), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rd_en(r_rd_en)
    );

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver: one write cycle on a side, then one idle cycle.
    task automatic sem_write(input int side, input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (side == 0) begin
            l_sel = 1; l_oe = 0; l_rd_wr = 0; l_addr = a; l_wdata = d;
        end else begin
            r_sel = 1; r_oe = 0; r_rd_wr = 0; r_addr = a; r_wdata = d;
        end
        @(negedge clk);
        if (side == 0) chk("R11 left write keeps bus quiet", {l_rd_en, l_rdata}, '0);
        else           chk("R11 right write keeps bus quiet", {r_rd_en, r_rdata}, '0);
        step();
        if (side == 0) begin l_sel = 0; l_rd_wr = 1; end
        else           begin r_sel = 0; r_rd_wr = 1; end
        step();
    endtask

    // Driver: an n-cycle read; pushes one expected word per cycle to the scoreboard.
    task automatic sem_read(input int side, input logic [AW-1:0] a, input logic b,
                            input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            if (side == 0) begin l_exp_q.push_back({DW{b}}); l_tag_q.push_back(tag); end
            else           begin r_exp_q.push_back({DW{b}}); r_tag_q.push_back(tag); end
        end
        if (side == 0) begin l_sel = 1; l_oe = 1; l_rd_wr = 1; l_addr = a; end
        else           begin r_sel = 1; r_oe = 1; r_rd_wr = 1; r_addr = a; end
        repeat (n) @(posedge clk);
        #1;
        if (side == 0) begin l_sel = 0; l_oe = 0; end
        else           begin r_sel = 0; r_oe = 0; end
        step();
    endtask

    // Monitor: compare every driven read word against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && l_rd_en) begin
                if (l_exp_q.size() == 0) chk("R11 left unexpected read", l_rdata, 'x);
                else chk(l_tag_q.pop_front(), l_rdata, l_exp_q.pop_front());
            end
            if (!rst && r_rd_en) begin
                if (r_exp_q.size() == 0) chk("R11 right unexpected read", r_rdata, 'x);
                else chk(r_tag_q.pop_front(), r_rdata, r_exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R0 watchdog expired got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        step();

        // R10: all flags free on both sides after reset
        for (int i = 0; i < 8; i++) begin
            sem_read(0, AW'(i), 1'b1, 1, "R10 left free after reset");
            sem_read(1, AW'(i), 1'b1, 1, "R10 right free after reset");
        end

        // R11: select low with read strobes high drives nothing
        l_oe = 1; l_rd_wr = 1; l_sel = 0;
        @(negedge clk);
        chk("R11 idle left bus", {l_rd_en, l_rdata}, '0);
        step(); l_oe = 0;

        // R3: left claims flag 0 by write-then-read
        sem_write(0, 13'd0, 18'h0);
        sem_read(0, 13'd0, 1'b0, 1, "R3 left owns flag0");
        sem_read(1, 13'd0, 1'b1, 1, "R3 right locked out flag0");

        // R1/R2: high address bits and stray data bits ignored
        sem_write(0, 13'h1AB3, 18'h3FFFE);
        sem_read(0, 13'h0F03, 1'b0, 1, "R1 flag3 claimed via high addr bits");
        sem_read(0, 13'd2, 1'b1, 1, "R1 flag2 untouched");
        sem_read(1, 13'd3, 1'b1, 1, "R2 right sees flag3 owned");

        // R4: non-owner release has no effect
        sem_write(1, 13'd0, 18'h1);
        sem_read(0, 13'd0, 1'b0, 1, "R4 left still owns flag0");
        sem_read(1, 13'd0, 1'b1, 1, "R4 right still out flag0");

        // R5: pending request then handover
        sem_write(1, 13'd0, 18'h0);
        sem_read(1, 13'd0, 1'b1, 1, "R5 right pending reads 1");
        sem_write(0, 13'd0, 18'h3FFFF);
        sem_read(1, 13'd0, 1'b0, 1, "R5 right gets flag0 on handover");
        sem_read(0, 13'd0, 1'b1, 1, "R5 left released flag0");

        // R6: release with nothing pending frees the flag
        sem_write(1, 13'd0, 18'h1);
        sem_read(0, 13'd0, 1'b1, 1, "R6 flag0 free left");
        sem_read(1, 13'd0, 1'b1, 1, "R6 flag0 free right");

        // R9: same-cycle claim, left wins, right pending
        fork
            sem_write(0, 13'd5, 18'h0);
            sem_write(1, 13'd5, 18'h0);
        join
        sem_read(0, 13'd5, 1'b0, 1, "R9 left wins tie");
        sem_read(1, 13'd5, 1'b1, 1, "R9 right loses tie");
        sem_write(0, 13'd5, 18'h1);
        sem_read(1, 13'd5, 1'b0, 1, "R9 right pending granted");
        sem_write(1, 13'd5, 18'h1);
        sem_read(0, 13'd5, 1'b1, 1, "R6 flag5 free after right release");

        // R8: read value frozen while handover happens mid-access
        sem_write(0, 13'd6, 18'h0);
        sem_write(1, 13'd6, 18'h0);
        fork
            sem_read(1, 13'd6, 1'b1, 4, "R8 right read frozen");
            begin
                step();
                sem_write(0, 13'd6, 18'h1);
            end
        join
        sem_read(1, 13'd6, 1'b0, 2, "R8 right fresh read sees ownership");
        sem_write(1, 13'd6, 18'h1);

        // R12: withdrawn pending request, owner release frees flag
        sem_write(0, 13'd4, 18'h0);
        sem_write(1, 13'd4, 18'h0);
        sem_write(1, 13'd4, 18'h1);
        sem_write(0, 13'd4, 18'h1);
        sem_read(1, 13'd4, 1'b1, 1, "R12 right not granted after withdraw");
        sem_read(0, 13'd4, 1'b1, 1, "R12 flag4 free");

        // R10: mid-run reset frees held flags (flag3 left, flag7 right)
        sem_write(1, 13'd7, 18'h0);
        sem_read(1, 13'd7, 1'b0, 1, "R3 right owns flag7");
        rst = 1; step(); rst = 0; step();
        sem_read(0, 13'd3, 1'b1, 1, "R10 flag3 freed by reset");
        sem_read(1, 13'd7, 1'b1, 1, "R10 flag7 freed by reset");
        sem_read(0, 13'd7, 1'b1, 1, "R10 flag7 free left");

        step();
        chk("R7 left scoreboard drained", DW'(l_exp_q.size()), '0);
        chk("R7 right scoreboard drained", DW'(r_exp_q.size()), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule